// File: doc/BRIEF.md
# Lockable Fault Capture Register

This block keeps a single fault record that both hardware and software can fill. The record is a status word, made up of a source index and a valid flag, plus a fixed number of payload words. Each hardware fault source drives a request strobe and a payload of its own, and a software-writable mask register turns each source on or off. When an enabled source requests while the record is empty, the block stores that source's index and payload and sets the valid flag in the same clock edge. From then on the record is locked, so handler code can read it without it being changed underneath.

Software releases the record by writing the valid flag back to zero. Software can also post a record of its own. It first writes the payload words and then writes the status word with the valid flag set and any index it likes, whether or not that index belongs to a real source. A hardware capture that lands during such a sequence overwrites whatever software had staged. Enabled requests that arrive while the record is locked are dropped, and each one is reported on a one-cycle overflow pulse.

All registers sit on a simple single-cycle register bus: a write strobe, a word address and write data, with combinational read data for the current address.

Top module: `fault_record`

## Requirements
- R1: After reset the status word, the mask register and every payload word read as zero, and the valid flag is low.
- R2: When the valid flag is low and at least one enabled source requests, the next clock edge sets the valid flag, loads the winning source number into the index field and loads that source's payload words. Payload word k of source n sits at bits (n*NDATA+k)*32 upward in the flat payload input.
- R3: A request from a source whose mask bit is zero causes no capture and no overflow pulse.
- R4: When several enabled sources request in the same cycle, the source with the lowest number is captured.
- R5: While the valid flag is high, bus writes to the index field or to any payload word are ignored, and so is a new hardware capture.
- R6: Writing the status word with bit 31 at zero while the record is locked clears the valid flag and leaves the stored index unchanged. After that the payload words accept writes again.
- R7: While the record is free, a status write loads bit 31 into the valid flag and bits 6:0 into the index, for any index value and whatever the mask holds. Payload words written beforehand are kept.
- R8: If a hardware capture and a bus write to the status word or to a payload word fall in the same cycle while the record is free, the hardware index and payload are stored and the bus values are discarded.
- R9: Each cycle in which an enabled source requests while the record is locked produces a one-cycle high on the overflow output at the next edge, and the record stays unchanged.
- R10: Word address 0 reads the status word with the valid flag in bit 31, the index in bits 6:0 and zeros in bits 30:7. Address 1 reads the mask, addresses 2 to 2+NDATA-1 read the payload words, and every other address reads zero.
- R11: The mask register is 32 bits wide, can be written at any time and reads back what was written. Bit n enables source n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (4) | Word address |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data for reg_addr |
| flt_req | input | NSRC (8) | Per-source fault request |
| flt_data | input | NSRC*NDATA*DW (1024) | Flat per-source payload words |
| rec_valid | output | 1 | Record valid / lock flag |
| rec_idx | output | IDXW (7) | Stored source index |
| ovf_pulse | output | 1 | One-cycle pulse for each dropped fault |

## Verification
A table of request and mask pairs drives the capture path. The table includes single sources at both ends of the range, several sources together with all of them enabled, the same pattern with only the higher source enabled, and requests that are all masked off. Together these separate a correct lowest-number pick from a highest-number pick and from a pick that ignores the mask. Directed sequences then cover the software posting of a record, writes that meet a locked record, release, and same-cycle collisions between bus writes and captures. These tell apart a lock that holds only the index from one that also holds the payload, and hardware priority from software priority. Overflow is driven with enabled and with masked requests against a locked record.

// File: rtl/fltrec_pkg.sv
package fltrec_pkg;
   // word addresses of the register map
   localparam int unsigned ADR_STAT  = 0;
   localparam int unsigned ADR_MASK  = 1;
   localparam int unsigned ADR_DATA0 = 2;
   // status word layout
   localparam int unsigned STAT_VALID_BIT = 31;
endpackage

// File: rtl/fltrec_pick.sv
module fltrec_pick #(
   parameter int unsigned NSRC  = 8,
   parameter int unsigned IDXW  = 7,
   parameter int unsigned DW    = 32,
   parameter int unsigned NDATA = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NSRC-1:0]             req_en,
   input  logic [NSRC*NDATA*DW-1:0]    payload,
   output logic                        hit,
   output logic [IDXW-1:0]             win_idx,
   output logic [NDATA*DW-1:0]         win_data
);
   localparam int unsigned SLICE = NDATA*DW;

   logic [NSRC-1:0] grant;

   // lowest-numbered requester wins
   always_comb begin
      grant   = '0;
      win_idx = '0;
      for (int i = NSRC-1; i >= 0; i--) begin
         if (req_en[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            win_idx  = IDXW'(i);
         end
      end
   end

   assign hit = |req_en;

   // and-or payload selector, one lane per source
   logic [SLICE-1:0] lane [NSRC];
   for (genvar g = 0; g < NSRC; g++) begin : g_lane
      assign lane[g] = {SLICE{grant[g]}} & payload[g*SLICE +: SLICE];
   end

   always_comb begin
      win_data = '0;
      for (int i = 0; i < NSRC; i++) win_data = win_data | lane[i];
   end

   // R4
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (hit == (grant != '0)));
   // R4
   grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ((req_en & (grant - NSRC'(1))) == '0));
endmodule

// File: rtl/fltrec_store.sv
module fltrec_store #(
   parameter int unsigned IDXW  = 7,
   parameter int unsigned DW    = 32,
   parameter int unsigned NDATA = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   hw_cap,
   input  logic [IDXW-1:0]        hw_idx,
   input  logic [NDATA*DW-1:0]    hw_data,
   input  logic                   sw_stat_we,
   input  logic                   sw_valid,
   input  logic [IDXW-1:0]        sw_idx,
   input  logic [NDATA-1:0]       sw_data_we,
   input  logic [DW-1:0]          sw_wdata,
   output logic                   valid,
   output logic [IDXW-1:0]        idx,
   output logic [NDATA*DW-1:0]    data
);
   // status: hardware capture first, then software
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         idx   <= '0;
      end else if (hw_cap) begin
         valid <= 1'b1;
         idx   <= hw_idx;
      end else if (sw_stat_we) begin
         valid <= sw_valid;
         if (!valid) idx <= sw_idx;
      end
   end

   for (genvar k = 0; k < NDATA; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            data[k*DW +: DW] <= '0;
         else if (hw_cap)
            data[k*DW +: DW] <= hw_data[k*DW +: DW];
         else if (sw_data_we[k] && !valid)
            data[k*DW +: DW] <= sw_wdata;
      end

      // R5
      lock_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
         valid |=> (data[k*DW +: DW] == $past(data[k*DW +: DW])));
   end

   // R5
   lock_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> (idx == $past(idx)));
   // R6
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && sw_stat_we && !sw_valid) |=> !valid);
   // R5
   no_cap_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hw_cap && valid));
endmodule

// File: rtl/fltrec_rdmux.sv
module fltrec_rdmux
   import fltrec_pkg::*;
#(
   parameter int unsigned AW    = 4,
   parameter int unsigned IDXW  = 7,
   parameter int unsigned DW    = 32,
   parameter int unsigned NDATA = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AW-1:0]          addr,
   input  logic                   valid,
   input  logic [IDXW-1:0]        idx,
   input  logic [DW-1:0]          mask,
   input  logic [NDATA*DW-1:0]    data,
   output logic [DW-1:0]          rdata
);
   logic [DW-1:0] stat_word;
   logic [DW-1:0] data_sel [NDATA];

   always_comb begin
      stat_word                 = '0;
      stat_word[IDXW-1:0]       = idx;
      stat_word[STAT_VALID_BIT] = valid;
   end

   for (genvar k = 0; k < NDATA; k++) begin : g_dsel
      assign data_sel[k] = (addr == AW'(ADR_DATA0 + k)) ? data[k*DW +: DW] : '0;
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(ADR_STAT)) rdata = stat_word;
      if (addr == AW'(ADR_MASK)) rdata = mask;
      for (int i = 0; i < NDATA; i++) rdata = rdata | data_sel[i];
   end

   // R10
   stat_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == AW'(ADR_STAT)) |-> (rdata[STAT_VALID_BIT-1:IDXW] == '0));
   // R10
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr >= AW'(ADR_DATA0 + NDATA)) |-> (rdata == '0));
endmodule

// File: rtl/fault_record.sv
module fault_record
   import fltrec_pkg::*;
#(
   parameter int unsigned NSRC  = 8,
   parameter int unsigned IDXW  = 7,
   parameter int unsigned DW    = 32,
   parameter int unsigned NDATA = 4,
   parameter int unsigned AW    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_we,
   input  logic [AW-1:0]              reg_addr,
   input  logic [DW-1:0]              reg_wdata,
   output logic [DW-1:0]              reg_rdata,
   input  logic [NSRC-1:0]            flt_req,
   input  logic [NSRC*NDATA*DW-1:0]   flt_data,
   output logic                       rec_valid,
   output logic [IDXW-1:0]            rec_idx,
   output logic                       ovf_pulse
);
   localparam int unsigned NWORDS = ADR_DATA0 + NDATA;

   // elaboration-time parameter checks
   if (DW != 32) begin : g_bad_dw
      $error("fault_record: DW must be 32");
   end
   if (NSRC < 1 || NSRC > DW || NSRC > (1 << IDXW)) begin : g_bad_nsrc
      $error("fault_record: NSRC out of range");
   end
   if (IDXW < 1 || IDXW >= STAT_VALID_BIT) begin : g_bad_idxw
      $error("fault_record: IDXW out of range");
   end
   if (NDATA < 1 || NWORDS > (1 << AW)) begin : g_bad_map
      $error("fault_record: register map does not fit AW");
   end

   logic [DW-1:0]          mask_q;
   logic [NSRC-1:0]        req_en;
   logic                   hit;
   logic [IDXW-1:0]        win_idx;
   logic [NDATA*DW-1:0]    win_data;
   logic                   hw_cap;
   logic                   stat_we;
   logic [NDATA-1:0]       data_we;
   logic [NDATA*DW-1:0]    rec_data;

   // mask register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 mask_q <= '0;
      else if (reg_we && reg_addr == AW'(ADR_MASK)) mask_q <= reg_wdata;
   end

   assign req_en  = flt_req & mask_q[NSRC-1:0];
   assign stat_we = reg_we && (reg_addr == AW'(ADR_STAT));

   for (genvar k = 0; k < NDATA; k++) begin : g_dwe
      assign data_we[k] = reg_we && (reg_addr == AW'(ADR_DATA0 + k));
   end

   fltrec_pick #(.NSRC(NSRC), .IDXW(IDXW), .DW(DW), .NDATA(NDATA)) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_en   (req_en),
      .payload  (flt_data),
      .hit      (hit),
      .win_idx  (win_idx),
      .win_data (win_data)
   );

   assign hw_cap = hit && !rec_valid;

   fltrec_store #(.IDXW(IDXW), .DW(DW), .NDATA(NDATA)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .hw_cap     (hw_cap),
      .hw_idx     (win_idx),
      .hw_data    (win_data),
      .sw_stat_we (stat_we),
      .sw_valid   (reg_wdata[STAT_VALID_BIT]),
      .sw_idx     (reg_wdata[IDXW-1:0]),
      .sw_data_we (data_we),
      .sw_wdata   (reg_wdata),
      .valid      (rec_valid),
      .idx        (rec_idx),
      .data       (rec_data)
   );

   // dropped-fault pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_pulse <= 1'b0;
      else        ovf_pulse <= hit && rec_valid;
   end

   fltrec_rdmux #(.AW(AW), .IDXW(IDXW), .DW(DW), .NDATA(NDATA)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (reg_addr),
      .valid (rec_valid),
      .idx   (rec_idx),
      .mask  (mask_q),
      .data  (rec_data),
      .rdata (reg_rdata)
   );

   // R2
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rec_valid && |(flt_req & mask_q[NSRC-1:0])) |=> rec_valid);
   // R9
   ovf_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && |(flt_req & mask_q[NSRC-1:0])) |=> ovf_pulse);
   // R3
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> $past(rec_valid && |(flt_req & mask_q[NSRC-1:0])));
endmodule

// File: tb/sim_fault_record.sv
module sim_fault_record;
   localparam int NSRC = 8, IDXW = 7, DW = 32, NDATA = 4, AW = 4;

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic                      reg_we = 1'b0;
   logic [AW-1:0]             reg_addr = '0;
   logic [DW-1:0]             reg_wdata = '0;
   logic [DW-1:0]             reg_rdata;
   logic [NSRC-1:0]           flt_req = '0;
   logic [NSRC*NDATA*DW-1:0]  flt_data;
   logic                      rec_valid;
   logic [IDXW-1:0]           rec_idx;
   logic                      ovf_pulse;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fault_record #(.NSRC(NSRC), .IDXW(IDXW), .DW(DW), .NDATA(NDATA), .AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flt_req(flt_req),
      .flt_data(flt_data), .rec_valid(rec_valid), .rec_idx(rec_idx),
      .ovf_pulse(ovf_pulse)
   );

   function automatic logic [31:0] pw(int n, int k);
      return 32'hF000_0000 | (32'(n) << 8) | 32'(k);
   endfunction

   initial begin
      for (int n = 0; n < NSRC; n++)
         for (int k = 0; k < NDATA; k++)
            flt_data[(n*NDATA+k)*DW +: DW] = pw(n, k);
   end

   // {req[23:16], mask[15:8], exp_valid[7], exp_idx[6:0]}
   localparam logic [23:0] VEC [8] = '{
      {8'h01, 8'hFF, 1'b1, 7'd0},
      {8'h80, 8'hFF, 1'b1, 7'd7},
      {8'h0A, 8'hFF, 1'b1, 7'd1},
      {8'h0A, 8'h08, 1'b1, 7'd3},
      {8'hF0, 8'h0F, 1'b0, 7'd0},
      {8'h00, 8'hFF, 1'b0, 7'd0},
      {8'hFF, 8'hC0, 1'b1, 7'd6},
      {8'h24, 8'h20, 1'b1, 7'd5}
   };

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      reg_addr = AW'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(logic [NSRC-1:0] r);
      @(negedge clk);
      flt_req = r;
      @(negedge clk);
      flt_req = '0;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0, v); chk("R1 status", v, 32'h0);
      rd(1, v); chk("R1 mask", v, 32'h0);
      for (int k = 0; k < NDATA; k++) begin
         rd(2 + k, v); chk("R1 data", v, 32'h0);
      end

      // R2 R3 R4 vector table
      for (int i = 0; i < 8; i++) begin
         logic [7:0] rq, mk; logic ev; logic [6:0] ei;
         {rq, mk, ev, ei} = VEC[i];
         wr(0, 32'h0);
         wr(1, {24'h0, mk});
         pulse(rq);
         chk("R3 no ovf on free", {31'h0, ovf_pulse}, 32'h0);
         if (ev) begin
            rd(0, v); chk("R2 R4 status", v, 32'h8000_0000 | 32'(ei));
            for (int k = 0; k < NDATA; k++) begin
               rd(2 + k, v); chk("R2 data", v, pw(int'(ei), k));
            end
         end else begin
            rd(0, v); chk("R3 masked no capture", v[31:31], 1'b0);
         end
      end

      // R11 mask readback
      wr(1, 32'hA5A5_00C3);
      rd(1, v); chk("R11 mask", v, 32'hA5A5_00C3);

      // R7 software post, mask does not gate
      wr(1, 32'h0);
      wr(0, 32'h0);
      for (int k = 0; k < NDATA; k++) wr(2 + k, 32'h1111_0000 + 32'(k));
      wr(0, 32'h8000_0055);
      rd(0, v); chk("R7 status", v, 32'h8000_0055);
      for (int k = 0; k < NDATA; k++) begin
         rd(2 + k, v); chk("R7 data", v, 32'h1111_0000 + 32'(k));
      end

      // R5 lock against bus writes
      wr(2, 32'hDEAD_BEEF);
      wr(0, 32'h8000_0011);
      rd(0, v); chk("R5 idx locked", v, 32'h8000_0055);
      rd(2, v); chk("R5 data locked", v, 32'h1111_0000);

      // R6 release
      wr(0, 32'h0000_0022);
      rd(0, v); chk("R6 release", v, 32'h0000_0055);
      wr(2, 32'hCAFE_0001);
      rd(2, v); chk("R6 data writable", v, 32'hCAFE_0001);

      // R10 padding and unmapped
      wr(0, 32'hFFFF_FFFF);
      rd(0, v); chk("R10 status pad", v, 32'h8000_007F);
      rd(9, v); chk("R10 unmapped", v, 32'h0);
      rd(15, v); chk("R10 unmapped top", v, 32'h0);

      // R8 status write collides with capture
      wr(0, 32'h0);
      wr(1, 32'hFF);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(0); reg_wdata = 32'h8000_0033; flt_req = 8'h04;
      @(negedge clk);
      reg_we = 1'b0; flt_req = '0;
      rd(0, v); chk("R8 status collision", v, 32'h8000_0002);

      // R8 data write collides with capture
      wr(0, 32'h0);
      wr(2, 32'h0000_1234);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(3); reg_wdata = 32'h0000_BEEF; flt_req = 8'h02;
      @(negedge clk);
      reg_we = 1'b0; flt_req = '0;
      rd(2, v); chk("R8 data0 overwritten", v, pw(1, 0));
      rd(3, v); chk("R8 data1 hw wins", v, pw(1, 1));
      rd(0, v); chk("R8 idx", v, 32'h8000_0001);

      // R9 dropped fault while locked
      @(negedge clk);
      flt_req = 8'h01;
      @(negedge clk);
      flt_req = '0;
      chk("R9 ovf pulse", {31'h0, ovf_pulse}, 32'h1);
      @(negedge clk);
      chk("R9 ovf one cycle", {31'h0, ovf_pulse}, 32'h0);
      rd(0, v); chk("R9 record unchanged", v, 32'h8000_0001);
      rd(2, v); chk("R9 data unchanged", v, pw(1, 0));

      // R3 masked request while locked gives no pulse
      wr(1, 32'hFE);
      pulse(8'h01);
      chk("R3 masked no ovf", {31'h0, ovf_pulse}, 32'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule